// File: doc/BRIEF.md
# Gated Event Timer

This block is a 16-bit up-counter that advances on single-cycle count ticks. The ticks first pass through a power-of-two prescaler and then through a gate stage. The gate stage decides whether a tick may count. A control register turns the timer on, picks the prescale ratio and holds a clock-select field. A gate register enables gating and picks one of four gate sources. It also sets the gate polarity and chooses between three gate behaviours: plain level, toggle, or single-pulse one-shot.

Software loads and reads the counter as two byte registers. In toggle mode, one full period of the gate source becomes one count window, so the counter measures that period. In single-pulse mode, software sets a go bit. The counter then accumulates over exactly one gate window. After that window, go drops by itself and a sticky gate-event flag is raised. A separate sticky flag records every wrap of the counter from 0xFFFF to 0x0000.

Top module: `gated_timer`

## Requirements
- R1: After reset the counter reads 0x0000, both sticky flags read 0, the control register reads 0x00, and the gate register reads 0x00 while all gate sources are low.
- R2: Writing the low or the high byte loads that byte on the next clock, and the 16-bit count reads back as {high, low}. A byte write in the same cycle as a counted tick wins over the increment.
- R3: While control bit 0 (on) is 0, ticks do not change the counter.
- R4: Control bits 5:4 hold the prescale code. Codes 0, 1, 2 and 3 give one count per 1, 2, 4 and 8 qualified ticks. Any control write restarts the prescale phase.
- R5: An increment from 0xFFFF gives 0x0000 and sets a sticky overflow flag. Only ovf_clr_i clears that flag.
- R6: With gate bit 7 (enable) at 0, every tick counts while the timer is on, whatever the gate sources do.
- R7: With the gate enabled, gate bits 1:0 pick gate_src_i[0] (pin), [1] (other timer overflow), [2] (comparator 1) or [3] (comparator 2). Gate bit 6 at 0 makes a high source active and at 1 makes a low source active. Ticks count only while the adjusted gate is active, and gate bit 2 reads the current adjusted gate level.
- R8: With gate bit 5 (toggle) at 1, the effective gate flips on each rising edge of the adjusted source and takes effect from the next cycle. Clearing bit 5 resets the toggle state to closed.
- R9: With gate bit 4 (single-pulse) at 1, writing gate bit 3 (go) as 1 arms the gate. Counting starts with the first cycle of the next rising edge of the effective gate, even if the gate is already high when go is written, and lasts while it stays high. When the gate falls, go reads 0 and the gate-event flag is set.
- R10: A go bit written while single-pulse is 0 is ignored and reads back 0.
- R11: The gate-event flag is sticky until gate_irq_clr_i is pulsed.
- R12: Control bits 7:6 (clock select) and all other control bits read back as written, and bits 7:6 have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Write data for all registers |
| ctrl_we_i | input | 1 | Write strobe, control register |
| gate_we_i | input | 1 | Write strobe, gate register |
| cnt_lo_we_i | input | 1 | Write strobe, counter low byte |
| cnt_hi_we_i | input | 1 | Write strobe, counter high byte |
| tick_i | input | 1 | Single-cycle count tick |
| gate_src_i | input | 4 | Gate sources: pin, timer overflow, comparator 1, comparator 2 |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| gate_irq_clr_i | input | 1 | Clears the gate-event flag |
| ctrl_o | output | 8 | Control register readback |
| gate_o | output | 8 | Gate register readback with go and live gate level |
| cnt_lo_o | output | 8 | Counter low byte |
| cnt_hi_o | output | 8 | Counter high byte |
| ovf_o | output | 1 | Sticky overflow flag |
| gate_irq_o | output | 1 | Sticky gate-event flag |

## Verification
The assertions take for granted that every input, gate sources included, is already synchronous to clk_i and stable for the whole cycle. Edge detection is done on the sampled level and assumes no glitches. They also take for granted that software does not write the gate register during a single-pulse window it wants completed, because a write abandons the window. The stimulus changes all inputs only on the falling clock edge. It keeps ticks low during register writes and gate-source pulses, and it rearms single-pulse mode only while no window is open.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int SRC_N = 4;
  localparam int SEL_W = $clog2(SRC_N);

  typedef struct packed {
    logic             en;
    logic             inv;
    logic             tgl;
    logic             spm;
    logic [SEL_W-1:0] sel;
  } gate_cfg_t;
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_code_i,
  output logic            inc_o
);
  localparam int PC_W = (2 ** PS_W) - 1;

  logic [PC_W-1:0] pc_q, limit;
  logic            last;

  assign limit = PC_W'((32'd1 << ps_code_i) - 32'd1);
  assign last  = (pc_q == limit);
  assign inc_o = tick_i & last & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (restart_i) pc_q <= '0;
    else if (tick_i)    pc_q <= last ? '0 : pc_q + PC_W'(1);
  end

  p_phase_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !inc_o || limit == '0);
endmodule

// File: rtl/gt_gate_ctrl.sv
module gt_gate_ctrl
  import gt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic [SRC_N-1:0] src_i,
  input  logic             irq_clr_i,
  output gate_cfg_t        cfg_o,
  output logic             go_o,
  output logic             gval_o,
  output logic             open_o,
  output logic             irq_o
);
  gate_cfg_t cfg_q;
  logic go_q, tog_q, lvl_q, b_q, win_q, irq_q;
  logic lvl, b, done;
  logic unused_wbit;

  assign unused_wbit = cfg_wdata_i[2];

  assign lvl  = src_i[cfg_q.sel] ^ cfg_q.inv;
  assign b    = cfg_q.tgl ? tog_q : lvl;
  assign done = cfg_q.spm & go_q & win_q & ~b;
  // one-shot: open from the rising cycle until the fall
  assign open_o = cfg_q.spm ? (go_q & b & (win_q | ~b_q)) : b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      go_q  <= 1'b0;
      tog_q <= 1'b0;
      lvl_q <= 1'b0;
      b_q   <= 1'b0;
      win_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      b_q   <= b;
      if (!cfg_q.tgl)         tog_q <= 1'b0;
      else if (lvl && !lvl_q) tog_q <= ~tog_q;

      if (cfg_we_i) begin
        cfg_q <= '{en: cfg_wdata_i[7], inv: cfg_wdata_i[6], tgl: cfg_wdata_i[5],
                   spm: cfg_wdata_i[4], sel: cfg_wdata_i[SEL_W-1:0]};
        go_q  <= cfg_wdata_i[4] & cfg_wdata_i[3];
        win_q <= 1'b0;
      end else if (!cfg_q.spm || done) begin
        go_q  <= 1'b0;
        win_q <= 1'b0;
      end else if (go_q && b && !b_q) begin
        win_q <= 1'b1;
      end

      if (done && !cfg_we_i) irq_q <= 1'b1;
      else if (irq_clr_i)    irq_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign go_o   = go_q;
  assign gval_o = b;
  assign irq_o  = irq_q;

  p_go_needs_spm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> cfg_q.spm);
  p_tgl_off_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.tgl |=> !tog_q);
  p_window_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.spm && go_q && win_q && !b && !cfg_we_i) |=> (irq_q && !go_q));
  p_no_open_unarmed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.spm && !go_q) |-> !open_o);
  p_irq_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic                inc_i,
  input  logic                ovf_clr_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                ovf_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, wr, step;

  assign wr   = lo_we_i | hi_we_i;
  assign step = inc_i & ~wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (lo_we_i) cnt_q[BYTE_W-1:0]     <= wdata_i;
      if (hi_we_i) cnt_q[CNT_W-1:BYTE_W] <= wdata_i;
      if (step)    cnt_q <= cnt_q + CNT_W'(1);
      if (step && (&cnt_q)) ovf_q <= 1'b1;
      else if (ovf_clr_i)   ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_wrap_sets_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_write_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> cnt_q[BYTE_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ctrl_we_i,
  input  logic              gate_we_i,
  input  logic              cnt_lo_we_i,
  input  logic              cnt_hi_we_i,
  input  logic              tick_i,
  input  logic [SRC_N-1:0]  gate_src_i,
  input  logic              ovf_clr_i,
  input  logic              gate_irq_clr_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [7:0]        gate_o,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic              ovf_o,
  output logic              gate_irq_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int PS_LO = 4;

  logic [BYTE_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt;
  gate_cfg_t         gcfg;
  logic              go, gval, gopen, qual, inc, on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= wdata_i;
  end

  assign on   = ctrl_q[0];
  assign qual = tick_i & on & (~gcfg.en | gopen);

  gt_gate_ctrl u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (gate_we_i),
    .cfg_wdata_i (wdata_i[7:0]),
    .src_i       (gate_src_i),
    .irq_clr_i   (gate_irq_clr_i),
    .cfg_o       (gcfg),
    .go_o        (go),
    .gval_o      (gval),
    .open_o      (gopen),
    .irq_o       (gate_irq_o)
  );

  gt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ctrl_we_i),
    .tick_i    (qual),
    .ps_code_i (ctrl_q[PS_LO +: PS_W]),
    .inc_o     (inc)
  );

  gt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .lo_we_i   (cnt_lo_we_i),
    .hi_we_i   (cnt_hi_we_i),
    .inc_i     (inc),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  assign ctrl_o   = ctrl_q;
  assign gate_o   = {gcfg.en, gcfg.inv, gcfg.tgl, gcfg.spm, go, gval, gcfg.sel};
  assign cnt_lo_o = cnt[BYTE_W-1:0];
  assign cnt_hi_o = cnt[CNT_W-1:BYTE_W];

  p_off_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on && !cnt_lo_we_i && !cnt_hi_we_i) |=> $stable(cnt));
  p_gate_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gcfg.en && !gopen && !cnt_lo_we_i && !cnt_hi_we_i) |=> $stable(cnt));
endmodule

// File: tb/gated_timer_test.sv
module gated_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       ctrl_we_i = 0, gate_we_i = 0, cnt_lo_we_i = 0, cnt_hi_we_i = 0;
  logic       tick_i = 0, ovf_clr_i = 0, gate_irq_clr_i = 0;
  logic [3:0] gate_src_i = '0;
  logic [7:0] ctrl_o, gate_o, cnt_lo_o, cnt_hi_o;
  logic       ovf_o, gate_irq_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  gated_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i),
    .ctrl_we_i(ctrl_we_i), .gate_we_i(gate_we_i),
    .cnt_lo_we_i(cnt_lo_we_i), .cnt_hi_we_i(cnt_hi_we_i),
    .tick_i(tick_i), .gate_src_i(gate_src_i),
    .ovf_clr_i(ovf_clr_i), .gate_irq_clr_i(gate_irq_clr_i),
    .ctrl_o(ctrl_o), .gate_o(gate_o), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
    .ovf_o(ovf_o), .gate_irq_o(gate_irq_o)
  );

  function automatic int cnt();
    return {cnt_hi_o, cnt_lo_o};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // writes: 0 ctrl, 1 gate, 2 lo, 3 hi
  task automatic wr(int which, logic [7:0] v);
    @(negedge clk_i);
    wdata_i = v;
    ctrl_we_i = (which == 0); gate_we_i = (which == 1);
    cnt_lo_we_i = (which == 2); cnt_hi_we_i = (which == 3);
    @(negedge clk_i);
    ctrl_we_i = 0; gate_we_i = 0; cnt_lo_we_i = 0; cnt_hi_we_i = 0;
  endtask

  task automatic setcnt(int v);
    wr(2, v[7:0]);
    wr(3, v[15:8]);
  endtask

  task automatic ticks(int n, logic [3:0] src);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1; gate_src_i = src;
    end
    @(negedge clk_i);
    tick_i = 0;
  endtask

  task automatic src_pulse(logic [3:0] src);
    @(negedge clk_i);
    gate_src_i = src;
    @(negedge clk_i);
    gate_src_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 cnt", cnt(), 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 irq", gate_irq_o, 0);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 gate", gate_o, 0);
  endtask

  task automatic t_off;
    ticks(5, 4'h0);
    chk("R3 off no count", cnt(), 0);
  endtask

  task automatic t_free;
    wr(0, 8'h01);
    ticks(10, 4'hF);
    chk("R6 ungated count", cnt(), 10);
    wr(0, 8'hC1);
    chk("R12 ctrl readback", ctrl_o, 8'hC1);
    setcnt(0);
    ticks(7, 4'h0);
    chk("R12 clock select no effect", cnt(), 7);
  endtask

  task automatic t_prescale;
    for (int c = 1; c < 4; c++) begin
      wr(0, 8'((c << 4) | 1));
      setcnt(0);
      ticks(16, 4'h0);
      chk("R4 prescale divide", cnt(), 16 >> c);
    end
    wr(0, 8'h21);
    setcnt(0);
    ticks(3, 4'h0);
    wr(0, 8'h21);
    ticks(3, 4'h0);
    chk("R4 phase restart", cnt(), 0);
    ticks(1, 4'h0);
    chk("R4 fourth tick counts", cnt(), 1);
  endtask

  task automatic t_write;
    wr(0, 8'h00);
    setcnt(16'h1234);
    chk("R2 low byte", cnt_lo_o, 8'h34);
    chk("R2 high byte", cnt_hi_o, 8'h12);
    wr(0, 8'h01);
    @(negedge clk_i);
    tick_i = 1; cnt_lo_we_i = 1; wdata_i = 8'h55;
    @(negedge clk_i);
    tick_i = 0; cnt_lo_we_i = 0;
    chk("R2 write beats tick", cnt(), 16'h1255);
  endtask

  task automatic t_wrap;
    wr(0, 8'h01);
    setcnt(16'hFFFE);
    ticks(1, 4'h0);
    chk("R5 no ovf before wrap", ovf_o, 0);
    ticks(1, 4'h0);
    chk("R5 wrap value", cnt(), 0);
    chk("R5 ovf set", ovf_o, 1);
    ticks(3, 4'h0);
    chk("R5 ovf sticky", ovf_o, 1);
    @(negedge clk_i); ovf_clr_i = 1;
    @(negedge clk_i); ovf_clr_i = 0;
    chk("R5 ovf cleared", ovf_o, 0);
  endtask

  task automatic t_gate_level;
    wr(0, 8'h01);
    for (int s = 0; s < 4; s++) begin
      logic [3:0] me;
      me = 4'(1 << s);
      wr(1, 8'(8'h80 | s));
      setcnt(0);
      ticks(4, ~me);
      chk("R7 other sources ignored", cnt(), 0);
      chk("R7 gate value low", gate_o[2], 0);
      ticks(4, me);
      chk("R7 selected source counts", cnt(), 4);
      chk("R7 gate value high", gate_o[2], 1);
      wr(1, 8'(8'hC0 | s));
      ticks(3, me);
      chk("R7 inverted blocks high", cnt(), 4);
      ticks(3, 4'h0);
      chk("R7 inverted counts low", cnt(), 7);
    end
    gate_src_i = '0;
  endtask

  task automatic t_toggle;
    wr(0, 8'h01);
    wr(1, 8'hA0);
    setcnt(0);
    ticks(3, 4'h0);
    chk("R8 closed before edge", cnt(), 0);
    src_pulse(4'h1);
    chk("R8 gate value after edge", gate_o[2], 1);
    ticks(5, 4'h0);
    chk("R8 window counts", cnt(), 5);
    src_pulse(4'h1);
    ticks(5, 4'h0);
    chk("R8 second edge closes", cnt(), 5);
    src_pulse(4'h1);
    ticks(3, 4'h0);
    chk("R8 reopens", cnt(), 8);
    wr(1, 8'h80);
    wr(1, 8'hA0);
    ticks(4, 4'h0);
    chk("R8 toggle state cleared", cnt(), 8);
  endtask

  task automatic t_single;
    wr(0, 8'h01);
    setcnt(0);
    wr(1, 8'h98);
    chk("R9 go armed", gate_o[3], 1);
    ticks(3, 4'h0);
    chk("R9 idle while low", cnt(), 0);
    ticks(4, 4'h1);
    chk("R9 window counts", cnt(), 4);
    @(negedge clk_i); tick_i = 1; gate_src_i = 4'h0;
    @(negedge clk_i); tick_i = 0;
    chk("R9 fall stops", cnt(), 4);
    chk("R9 go cleared", gate_o[3], 0);
    chk("R9 irq set", gate_irq_o, 1);
    ticks(4, 4'h1);
    chk("R9 one shot only", cnt(), 4);
    chk("R11 irq sticky", gate_irq_o, 1);
    @(negedge clk_i); gate_irq_clr_i = 1;
    @(negedge clk_i); gate_irq_clr_i = 0;
    chk("R11 irq cleared", gate_irq_o, 0);
    wr(1, 8'h88);
    chk("R10 go ignored", gate_o[3], 0);
    wr(1, 8'h98);
    ticks(3, 4'h1);
    chk("R9 no start when already high", cnt(), 4);
    ticks(1, 4'h0);
    ticks(2, 4'h1);
    chk("R9 start on next rise", cnt(), 6);
    gate_src_i = '0;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_off();
    t_free();
    t_prescale();
    t_write();
    t_wrap();
    t_gate_level();
    t_toggle();
    t_single();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule